// File: doc/BRIEF.md
# Elastic Rate Match FIFO

This block is an elastic buffer between two receive clocks of nearly equal frequency. Symbols arrive on the recovered clock, each a data byte plus a control flag. They leave on the local clock. Small frequency offsets between the far-end transmitter and the local receiver would otherwise make the buffer overflow or run dry. The block absorbs them by discarding skip symbols when it is running full and by adding skip symbols when it is running dry. Both actions are taken only in gaps between packets or in the idle stream, so packet contents are never altered.

The write side has no back-pressure, because a recovered stream cannot be paused. `in_valid` marks a symbol, and the symbol is lost if the buffer is full. The read side is pulled by the consumer. A cycle with `out_ready` high is one accepted read, and its symbol appears on `out_data`/`out_ctrl` with `out_valid` high on the next local clock edge. When nothing is requested, `out_valid` stays low. Read and write pointers cross between the domains in gray code, each through a two-flop synchronizer.

Each side computes its own fill level from its local pointer and the synchronized remote pointer. A skip symbol is defined as `in_ctrl`=1 with the byte equal to the `SKIP_CODE` parameter. A gap symbol is defined as `ctrl`=1 with the byte equal to `SKIP_CODE` or `IDLE_CODE`.

Top module: `skip_elastic_buffer`

## Requirements
- R1: After reset, `rd_empty` is 1, `wr_full` is 0 and `out_valid` is 0.
- R2: Stored symbols are delivered in the order they were written, with none lost or repeated.
- R3: `wr_full` is 1 while the write side counts DEPTH (16) entries. A write made while full is dropped. The flag clears once reads have freed space.
- R4: `rd_empty` is 1 while the read side counts no entries. A read made while empty returns `out_ctrl`=1 and `out_data`=`SKIP_CODE` (0xF7) and consumes nothing.
- R5: A skip symbol written while the write-side fill is above `HI_MARK` (12) is discarded. A skip written at a lower fill is stored.
- R6: A symbol with `in_ctrl`=0 is never discarded as a skip, even when its byte equals `SKIP_CODE`, and it never counts as a gap symbol.
- R7: On a read where the read-side fill is below `LO_MARK` (4) and the last symbol delivered was a gap symbol, the output is an inserted skip (`out_ctrl`=1, `out_data`=0xF7) and the read pointer holds.
- R8: On a read that follows a non-gap symbol, the next stored symbol is delivered even when the fill is below `LO_MARK`, so nothing is ever inserted inside a packet.
- R9: Each cross-domain pointer changes by at most one bit per clock.
- R10: `out_valid` is 1 exactly in the cycle after a cycle with `out_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered (write) clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| in_valid | input | 1 | Symbol present on the write side |
| in_data | input | 8 | Symbol byte |
| in_ctrl | input | 1 | Control flag of the symbol |
| wr_full | output | 1 | Buffer full, seen from the write side |
| rd_clk | input | 1 | Local (read) clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read domain |
| out_ready | input | 1 | Consumer accepts one symbol this cycle |
| out_valid | output | 1 | Output symbol present (one cycle after accept) |
| out_data | output | 8 | Output symbol byte |
| out_ctrl | output | 1 | Output symbol control flag |
| rd_empty | output | 1 | Buffer empty, seen from the read side |

## Verification
A wrong pointer or fill count on the write side shows up at the ports as a skip that should have been kept, or a data symbol that went missing. It can also show up as `wr_full` at the wrong count. Either is visible as soon as the stream is read back. A read-side fault gives an extra or missing inserted skip, or a repeated or skipped symbol, in the very next `out_valid` cycle. A late or stuck flag is seen within a few cycles once the synchronizer latency has passed.

// File: rtl/rmf_pkg.sv
package rmf_pkg;
  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_EMPTY  = 2'd1,
    RD_INSERT = 2'd2,
    RD_POP    = 2'd3
  } rd_act_e;
endpackage

// File: rtl/rmf_sync.sv
module rmf_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rmf_mem.sv
module rmf_mem #(
  parameter int AW = 4,
  parameter int W  = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/rmf_wr_ctl.sv
module rmf_wr_ctl #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter logic [DW-1:0] SKIP_CODE = 8'hF7,
  parameter int HI_MARK = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_ctrl,
  input  logic [AW:0]   rgray_sync,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          we,
  output logic          full
);
  localparam logic [AW:0] DEPTH_L = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0] HI_L    = HI_MARK[AW:0];
  localparam logic [AW:0] ONE_L   = {{AW{1'b0}}, 1'b1};

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b = g;
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0] wbin, wbin_nx, rbin, fill;
  logic        is_skip, drop_skip;

  assign rbin      = g2b(rgray_sync);
  assign fill      = wbin - rbin;
  assign full      = (fill == DEPTH_L);
  assign is_skip   = in_ctrl && (in_data == SKIP_CODE);
  assign drop_skip = is_skip && (fill > HI_L);
  assign we        = in_valid && !full && !drop_skip;
  assign wbin_nx   = wbin + ONE_L;
  assign waddr     = wbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (we) begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  a_r3_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full) |=> $stable(wgray));

  a_r5_skip_deleted_high: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ctrl && in_data == SKIP_CODE && fill > HI_L) |=> $stable(wgray));

  a_r6_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ctrl && !full) |=> !$stable(wgray));

  a_r9_wgray_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/rmf_rd_ctl.sv
module rmf_rd_ctl
  import rmf_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter logic [DW-1:0] SKIP_CODE = 8'hF7,
  parameter logic [DW-1:0] IDLE_CODE = 8'hBC,
  parameter int LO_MARK = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          out_ready,
  input  logic [AW:0]   wgray_sync,
  input  logic [DW:0]   rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_ctrl,
  output logic          empty
);
  localparam logic [AW:0] LO_L  = LO_MARK[AW:0];
  localparam logic [AW:0] ONE_L = {{AW{1'b0}}, 1'b1};

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b = g;
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0] rbin, rbin_nx, wbin, fill;
  logic        last_gap, rd_is_gap;
  rd_act_e     act;

  assign wbin      = g2b(wgray_sync);
  assign fill      = wbin - rbin;
  assign empty     = (fill == '0);
  assign rbin_nx   = rbin + ONE_L;
  assign raddr     = rbin[AW-1:0];
  assign rd_is_gap = rdata[DW] &&
                     ((rdata[DW-1:0] == SKIP_CODE) || (rdata[DW-1:0] == IDLE_CODE));

  always_comb begin
    if (!out_ready)                 act = RD_IDLE;
    else if (empty)                 act = RD_EMPTY;
    else if (fill < LO_L && last_gap) act = RD_INSERT;
    else                            act = RD_POP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ctrl  <= 1'b0;
      last_gap  <= 1'b1;
    end else begin
      out_valid <= (act != RD_IDLE);
      case (act)
        RD_EMPTY, RD_INSERT: begin
          out_data <= SKIP_CODE;
          out_ctrl <= 1'b1;
          last_gap <= 1'b1;
        end
        RD_POP: begin
          out_data <= rdata[DW-1:0];
          out_ctrl <= rdata[DW];
          last_gap <= rd_is_gap;
          rbin     <= rbin_nx;
          rgray    <= rbin_nx ^ (rbin_nx >> 1);
        end
        default: ;
      endcase
    end
  end

  a_r4_empty_read_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && empty) |=> (out_valid && out_ctrl && out_data == SKIP_CODE && $stable(rgray)));

  a_r7_insert_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !empty && fill < LO_L && last_gap) |=>
      ($stable(rgray) && out_ctrl && out_data == SKIP_CODE));

  a_r8_no_insert_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !empty && !last_gap) |=> !$stable(rgray));

  a_r10_valid_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(out_ready));

  a_r9_rgray_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/skip_elastic_buffer.sv
module skip_elastic_buffer #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter logic [DW-1:0] SKIP_CODE = 8'hF7,
  parameter logic [DW-1:0] IDLE_CODE = 8'hBC,
  parameter int HI_MARK = 12,
  parameter int LO_MARK = 4
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_ctrl,
  output logic          wr_full,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_ctrl,
  output logic          rd_empty
);
  localparam int PW = AW + 1;
  localparam int SW = DW + 1;

  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          we;
  logic [SW-1:0] rdata;

  rmf_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_s)
  );

  rmf_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_s)
  );

  rmf_mem #(.AW(AW), .W(SW)) u_mem (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata({in_ctrl, in_data}),
    .raddr(raddr), .rdata(rdata)
  );

  rmf_wr_ctl #(.AW(AW), .DW(DW), .SKIP_CODE(SKIP_CODE), .HI_MARK(HI_MARK)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ctrl(in_ctrl), .rgray_sync(rgray_s), .wgray(wgray), .waddr(waddr),
    .we(we), .full(wr_full)
  );

  rmf_rd_ctl #(.AW(AW), .DW(DW), .SKIP_CODE(SKIP_CODE), .IDLE_CODE(IDLE_CODE),
               .LO_MARK(LO_MARK)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .out_ready(out_ready), .wgray_sync(wgray_s),
    .rdata(rdata), .raddr(raddr), .rgray(rgray), .out_valid(out_valid),
    .out_data(out_data), .out_ctrl(out_ctrl), .empty(rd_empty)
  );
endmodule

// File: tb/test_skip_elastic_buffer.sv
module test_skip_elastic_buffer;
  logic       wr_clk = 1'b0, rd_clk = 1'b0;
  logic       wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic       in_valid = 1'b0, in_ctrl = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic       wr_full, out_valid, out_ctrl, rd_empty;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;

  localparam logic [7:0] SKIP = 8'hF7;

  // {keep, ctrl, data}: sixteen kept entries, the last one fills the buffer
  localparam int NV = 19;
  localparam logic [9:0] VEC [NV] = '{
    10'h210, 10'h211, 10'h3F7, 10'h2F7, 10'h214, 10'h215, 10'h216,
    10'h217, 10'h218, 10'h219, 10'h21A, 10'h21B, 10'h21C,
    10'h1F7, 10'h2F7, 10'h1F7, 10'h220, 10'h221, 10'h022
  };

  always #5 wr_clk = ~wr_clk;
  initial begin
    #3;
    forever #5 rd_clk = ~rd_clk;
  end

  skip_elastic_buffer i_skip_elastic_buffer (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ctrl(in_ctrl), .wr_full(wr_full), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ctrl(out_ctrl), .rd_empty(rd_empty)
  );

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic ctrl, input logic [7:0] data);
    @(negedge wr_clk);
    in_valid = 1'b1; in_ctrl = ctrl; in_data = data;
    @(negedge wr_clk);
    in_valid = 1'b0;
  endtask

  // one accepted read; result sampled after the edge that captured it
  task automatic pull(output logic [9:0] got);
    @(negedge rd_clk);
    out_ready = 1'b1;
    @(negedge rd_clk);
    out_ready = 1'b0;
    got = {out_valid, out_ctrl, out_data};
  endtask

  task automatic settle();
    repeat (8) @(negedge wr_clk);
    repeat (8) @(negedge rd_clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0] got;
    logic [8:0] exp_q [32];
    int n_exp = 0;

    repeat (3) @(negedge wr_clk);
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;
    @(negedge rd_clk);
    check("R1 reset flags", {7'd0, rd_empty, wr_full, out_valid}, 10'b100);

    // vector walk: reader idle, so the write-side fill equals the number stored
    for (int i = 0; i < NV; i++) begin
      put(VEC[i][8], VEC[i][7:0]);
      if (VEC[i][9]) begin
        exp_q[n_exp] = VEC[i][8:0];
        n_exp++;
      end
    end
    settle();
    check("R3 full at depth", {9'd0, wr_full}, 10'd1);
    check("R4 not empty", {9'd0, rd_empty}, 10'd0);
    check("R10 no valid without ready", {9'd0, out_valid}, 10'd0);

    // R2 R5 R6 R8: exactly the kept entries come back in order, no insertion
    for (int i = 0; i < n_exp; i++) begin
      pull(got);
      check("R2/R5/R6/R8 stream order", got, {1'b1, exp_q[i]});
    end
    check("R5 kept count", 10'(n_exp), 10'd16);
    settle();
    check("R4 empty after drain", {9'd0, rd_empty}, 10'd1);
    check("R3 full clears", {9'd0, wr_full}, 10'd0);
    pull(got);
    check("R4 empty read skip", got, {2'b11, SKIP});

    // insertion: last output was a gap symbol and fill is 3
    put(1'b1, SKIP);
    put(1'b0, 8'h40);
    put(1'b0, 8'h41);
    settle();
    pull(got);
    check("R7 inserted skip", got, {2'b11, SKIP});
    put(1'b0, 8'h42);
    put(1'b0, 8'h43);
    settle();
    pull(got);
    check("R7 pointer held, stored skip next", got, {2'b11, SKIP});
    pull(got);
    check("R2 first packet byte", got, {2'b10, 8'h40});
    pull(got);
    check("R8 no insert after data at low fill", got, {2'b10, 8'h41});
    pull(got);
    check("R8 packet continues", got, {2'b10, 8'h42});
    pull(got);
    check("R2 last packet byte", got, {2'b10, 8'h43});
    pull(got);
    check("R4 empty again", got, {2'b11, SKIP});
    @(negedge rd_clk);
    check("R10 valid drops", {9'd0, out_valid}, 10'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule